// File: doc/BRIEF.md
# Open-Row Bank Tracker with Least-Recently-Used Replacement

This block sits in a DRAM memory controller, ahead of the command sequencer. It remembers which banks currently hold an open row, and which row that is, in a small set of slots (four by default). For each access request, given as a bank and a row, it decides which row commands the access needs. The access may hit a row that is already open, so no activate is needed. It may open the row in a free slot with a single activate. It may conflict with a different row in the same bank, which needs a precharge and an activate on that bank. Or it may find every slot taken, in which case the least recently used bank is precharged and the new row is activated in its slot.

Keeping several rows open cuts the number of precharge and activate pairs when accesses return to recent banks. A mode input limits the tracker to a single open bank, so every access to another bank closes the one that is open. A refresh input closes all rows at once and reports a precharge-all decision. Requests use a valid/ready handshake. Each accepted request yields exactly one decision, registered and presented the cycle after acceptance. Command timing and the DRAM protocol itself belong to other blocks.

Top module: `open_row_tracker`

## Requirements
- R1: After reset no row is open, `rsp_valid` is low and `req_ready` is high.
- R2: A request whose bank holds an open row with the same row address yields `rsp_act` = 0 (hit), with `rsp_slot` naming that slot, and the set of open banks is unchanged.
- R3: A request to a bank with no open row, while the capacity is not used up, yields `rsp_act` = 1 (open) in the lowest-numbered free slot.
- R4: A request to a bank whose open row differs yields `rsp_act` = 2 (row swap), with `rsp_close_bank` equal to the requested bank and the same slot reused.
- R5: With all SLOTS slots open in normal mode, a request to another bank yields `rsp_act` = 3 (evict), with `rsp_close_bank` the least recently used bank and its slot reused; no more than SLOTS banks are ever open.
- R6: Every hit, open, swap or evict makes the slot it names the most recently used one, so a hit protects a bank from the next eviction.
- R7: With `single_bank` high, at most one bank is open: a request to another bank while one is open yields evict (3) closing that bank.
- R8: A request is accepted when `req_valid` and `req_ready` are both high, and the decision appears with `rsp_valid` exactly one cycle later; `req_ready` is low while `refresh` is high; no `rsp_valid` appears without a preceding acceptance or refresh.
- R9: A `refresh` cycle yields `rsp_act` = 4 (precharge all) the next cycle, with `rsp_slot`, `rsp_close_bank`, `rsp_bank` and `rsp_row` all zero. All rows are then closed, so the next access to a previously open bank is an open (1), and a request offered during refresh is not taken.
- R10: After an eviction the new row is most recently used, so successive evictions close banks in order of their last use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| single_bank | input | 1 | High: only one bank may hold an open row (change only while no row is open) |
| refresh | input | 1 | Close all rows this cycle and report precharge-all |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BANK_W | Requested bank |
| req_row | input | ROW_W | Requested row |
| rsp_valid | output | 1 | Decision valid this cycle |
| rsp_act | output | 3 | 0 hit, 1 open, 2 row swap, 3 evict, 4 precharge all |
| rsp_slot | output | SLOT_W | Slot used by the decision |
| rsp_close_bank | output | BANK_W | Bank to precharge for swap or evict, otherwise 0 |
| rsp_bank | output | BANK_W | Bank to activate (echo of the request) |
| rsp_row | output | ROW_W | Row to activate (echo of the request) |

## Verification
The hardest state to reach is a full tracker whose recency order differs from the order in which the banks were opened, followed by an eviction; only then does the choice of victim show whether the age list is kept correctly. The stimulus opens four banks, hits the oldest one to move it to the front, forces a row swap on another, and then sends two new banks in a row, so that two evictions must close the two least recently used banks in turn. A refresh is raised while a request is offered, to show that the request is refused. A long pseudo-random run over eight banks and four rows then mixes every outcome, including back-to-back requests, in both modes.

// File: rtl/orow_pkg.sv
package orow_pkg;

   typedef enum logic [2:0] {
      ACT_HIT   = 3'd0,
      ACT_OPEN  = 3'd1,
      ACT_SWAP  = 3'd2,
      ACT_EVICT = 3'd3,
      ACT_PALL  = 3'd4
   } orow_act_e;

endpackage

// File: rtl/orow_match.sv
module orow_match #(
   parameter int SLOTS  = 4,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic [SLOTS-1:0]             slot_valid,
   input  logic [SLOTS-1:0][BANK_W-1:0] slot_bank,
   input  logic [SLOTS-1:0][ROW_W-1:0]  slot_row,
   input  logic [BANK_W-1:0]            req_bank,
   input  logic [ROW_W-1:0]             req_row,
   output logic                         bank_found,
   output logic [SLOT_W-1:0]            found_slot,
   output logic                         row_same
);

   logic [SLOTS-1:0] bank_eq;

   for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
      assign bank_eq[g] = slot_valid[g] && (slot_bank[g] == req_bank);
   end

   always_comb begin
      found_slot = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (bank_eq[i]) found_slot = SLOT_W'(i);
      end
   end

   assign bank_found = |bank_eq;
   assign row_same   = (slot_row[found_slot] == req_row);

endmodule

// File: rtl/orow_pick.sv
module orow_pick #(
   parameter int SLOTS = 4,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int AGE_W  = SLOT_W
) (
   input  logic [SLOTS-1:0]            slot_valid,
   input  logic [SLOTS-1:0][AGE_W-1:0] ages,
   input  logic                        single_bank,
   output logic                        is_full,
   output logic [SLOT_W-1:0]           free_slot,
   output logic [SLOT_W-1:0]           victim_slot
);

   logic [AGE_W-1:0] best_age;
   logic             seen_any;

   assign is_full = single_bank ? (|slot_valid) : (&slot_valid);

   always_comb begin
      free_slot = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (!slot_valid[i]) free_slot = SLOT_W'(i);
      end
   end

   always_comb begin
      victim_slot = '0;
      best_age    = '0;
      seen_any    = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (slot_valid[i] && (!seen_any || ages[i] > best_age)) begin
            victim_slot = SLOT_W'(i);
            best_age    = ages[i];
            seen_any    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/orow_age.sv
module orow_age #(
   parameter int SLOTS = 4,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int AGE_W  = SLOT_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        touch,
   input  logic [SLOT_W-1:0]           touch_slot,
   output logic [SLOTS-1:0][AGE_W-1:0] ages
);

   logic [AGE_W-1:0] touched_age;
   assign touched_age = ages[touch_slot];

   for (genvar g = 0; g < SLOTS; g++) begin : g_age
      logic [AGE_W-1:0] age_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age_r <= AGE_W'(g);
         end else if (touch) begin
            if (touch_slot == SLOT_W'(g))  age_r <= '0;
            else if (age_r < touched_age)  age_r <= age_r + AGE_W'(1);
         end
      end
      assign ages[g] = age_r;
   end

   logic [(2**AGE_W)-1:0] age_seen;
   always_comb begin
      age_seen = '0;
      for (int i = 0; i < SLOTS; i++) age_seen[ages[i]] = 1'b1;
   end

   // R6: the age list stays a permutation, so the recency order is total
   assert_age_permutation_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(age_seen) == SLOTS);

   // R6: a touched slot becomes the most recent one
   assert_touch_makes_mru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> ages[$past(touch_slot)] == '0);

endmodule

// File: rtl/open_row_tracker.sv
module open_row_tracker #(
   parameter int SLOTS  = 4,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int AGE_W  = SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              single_bank,
   input  logic              refresh,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   output logic              rsp_valid,
   output logic [2:0]        rsp_act,
   output logic [SLOT_W-1:0] rsp_slot,
   output logic [BANK_W-1:0] rsp_close_bank,
   output logic [BANK_W-1:0] rsp_bank,
   output logic [ROW_W-1:0]  rsp_row
);
   import orow_pkg::*;

   if (SLOTS < 2)            $error("open_row_tracker: SLOTS must be at least 2");
   if (SLOTS > 2**BANK_W)    $error("open_row_tracker: SLOTS exceeds the number of banks");
   if (ROW_W < 1)            $error("open_row_tracker: ROW_W must be positive");

   logic [SLOTS-1:0]             slot_valid;
   logic [SLOTS-1:0][BANK_W-1:0] slot_bank;
   logic [SLOTS-1:0][ROW_W-1:0]  slot_row;
   logic [SLOTS-1:0][AGE_W-1:0]  ages;

   logic              bank_found, row_same, is_full, accept;
   logic [SLOT_W-1:0] found_slot, free_slot, victim_slot;
   logic [SLOT_W-1:0] sel_slot;
   orow_act_e         sel_act;
   logic [BANK_W-1:0] sel_close;

   assign req_ready = !refresh;
   assign accept    = req_valid && req_ready;

   orow_match #(.SLOTS(SLOTS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_match (
      .slot_valid (slot_valid),
      .slot_bank  (slot_bank),
      .slot_row   (slot_row),
      .req_bank   (req_bank),
      .req_row    (req_row),
      .bank_found (bank_found),
      .found_slot (found_slot),
      .row_same   (row_same)
   );

   orow_pick #(.SLOTS(SLOTS)) u_pick (
      .slot_valid  (slot_valid),
      .ages        (ages),
      .single_bank (single_bank),
      .is_full     (is_full),
      .free_slot   (free_slot),
      .victim_slot (victim_slot)
   );

   orow_age #(.SLOTS(SLOTS)) u_age (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch      (accept),
      .touch_slot (sel_slot),
      .ages       (ages)
   );

   always_comb begin
      if (bank_found) begin
         sel_slot  = found_slot;
         sel_act   = row_same ? ACT_HIT : ACT_SWAP;
         sel_close = row_same ? '0 : req_bank;
      end else if (!is_full) begin
         sel_slot  = free_slot;
         sel_act   = ACT_OPEN;
         sel_close = '0;
      end else begin
         sel_slot  = victim_slot;
         sel_act   = ACT_EVICT;
         sel_close = slot_bank[victim_slot];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_valid <= '0;
         slot_bank  <= '0;
         slot_row   <= '0;
      end else if (refresh) begin
         slot_valid <= '0;
      end else if (accept) begin
         slot_valid[sel_slot] <= 1'b1;
         slot_bank[sel_slot]  <= req_bank;
         slot_row[sel_slot]   <= req_row;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_act        <= 3'(ACT_HIT);
         rsp_slot       <= '0;
         rsp_close_bank <= '0;
         rsp_bank       <= '0;
         rsp_row        <= '0;
      end else if (refresh) begin
         rsp_valid      <= 1'b1;
         rsp_act        <= 3'(ACT_PALL);
         rsp_slot       <= '0;
         rsp_close_bank <= '0;
         rsp_bank       <= '0;
         rsp_row        <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_act        <= 3'(sel_act);
            rsp_slot       <= sel_slot;
            rsp_close_bank <= sel_close;
            rsp_bank       <= req_bank;
            rsp_row        <= req_row;
         end
      end
   end

   // bank uniqueness across slots, driven apart from the decision logic
   logic dup_bank;
   always_comb begin
      dup_bank = 1'b0;
      for (int i = 0; i < SLOTS; i++)
         for (int j = i + 1; j < SLOTS; j++)
            if (slot_valid[i] && slot_valid[j] && slot_bank[i] == slot_bank[j]) dup_bank = 1'b1;
   end

   assert_bank_in_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_bank);

   assert_hit_keeps_open_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_act == 3'(ACT_HIT)) |-> slot_valid == $past(slot_valid));

   assert_evict_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_act == 3'(ACT_EVICT) && !$past(single_bank))
         |-> $countones($past(slot_valid)) == SLOTS);

   assert_single_bank_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (single_bank && $countones(slot_valid) <= 1) |=> $countones(slot_valid) <= 1);

   assert_rsp_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);

   assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid || refresh) |=> !rsp_valid);

   assert_refresh_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      refresh |=> (slot_valid == '0 && rsp_act == 3'(ACT_PALL)));

endmodule

// File: tb/open_row_tracker_tb.sv
module open_row_tracker_tb;
   localparam int SLOTS  = 4;
   localparam int BANK_W = 3;
   localparam int ROW_W  = 14;
   localparam int SLOT_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              single_bank = 1'b0;
   logic              refresh = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [BANK_W-1:0] req_bank = '0;
   logic [ROW_W-1:0]  req_row = '0;
   logic              rsp_valid;
   logic [2:0]        rsp_act;
   logic [SLOT_W-1:0] rsp_slot;
   logic [BANK_W-1:0] rsp_close_bank;
   logic [BANK_W-1:0] rsp_bank;
   logic [ROW_W-1:0]  rsp_row;

   always #2.5 clk = ~clk;

   open_row_tracker #(.SLOTS(SLOTS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .single_bank(single_bank), .refresh(refresh),
      .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
      .rsp_valid(rsp_valid), .rsp_act(rsp_act), .rsp_slot(rsp_slot),
      .rsp_close_bank(rsp_close_bank), .rsp_bank(rsp_bank), .rsp_row(rsp_row)
   );

   typedef struct packed {
      logic [2:0]        act;
      logic [SLOT_W-1:0] slot;
      logic [BANK_W-1:0] close;
      logic [BANK_W-1:0] bank;
      logic [ROW_W-1:0]  row;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 0;

   // reference model: slot contents and a recency list of slot numbers, front = newest
   bit                m_valid [SLOTS];
   logic [BANK_W-1:0] m_bank  [SLOTS];
   logic [ROW_W-1:0]  m_row   [SLOTS];
   int                m_order[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic to_front(input int s);
      foreach (m_order[k]) if (m_order[k] == s) begin m_order.delete(k); break; end
      m_order.push_front(s);
   endtask

   function automatic exp_t predict(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r);
      exp_t e;
      int   hs = -1, cnt = 0, cap;
      e.bank = b; e.row = r; e.close = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (m_valid[s]) cnt++;
         if (m_valid[s] && m_bank[s] == b) hs = s;
      end
      cap = single_bank ? 1 : SLOTS;
      if (hs >= 0) begin
         e.slot = SLOT_W'(hs);
         if (m_row[hs] == r) e.act = 3'd0;
         else begin e.act = 3'd2; e.close = b; end
      end else if (cnt < cap) begin
         e.act = 3'd1;
         e.slot = '0;
         for (int s = SLOTS - 1; s >= 0; s--) if (!m_valid[s]) e.slot = SLOT_W'(s);
      end else begin
         int v = -1;
         e.act = 3'd3;
         for (int k = m_order.size() - 1; k >= 0 && v < 0; k--)
            if (m_valid[m_order[k]]) v = m_order[k];
         e.slot  = SLOT_W'(v);
         e.close = m_bank[v];
      end
      return e;
   endfunction

   task automatic issue(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r, input string tag);
      exp_t  e;
      string t;
      @(negedge clk);
      refresh = 1'b0; req_valid = 1'b1; req_bank = b; req_row = r;
      @(posedge clk);
      e = predict(b, r);
      m_valid[e.slot] = 1'b1; m_bank[e.slot] = b; m_row[e.slot] = r;
      to_front(int'(e.slot));
      if (tag != "") t = tag;
      else case (e.act)
         3'd0: t = "R2";
         3'd1: t = "R3";
         3'd2: t = "R4";
         default: t = single_bank ? "R7" : "R5";
      endcase
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic do_refresh(input bit offer_req, input bit new_mode);
      exp_t e;
      @(negedge clk);
      refresh = 1'b1; req_valid = offer_req; req_bank = 3'd1; req_row = 14'd10;
      #1;
      check(req_ready == 1'b0, "R8", "req_ready during refresh", req_ready, 0);
      @(posedge clk);
      e = '0; e.act = 3'd4;
      for (int s = 0; s < SLOTS; s++) m_valid[s] = 1'b0;
      exp_q.push_back(e);
      tag_q.push_back("R9");
      @(negedge clk);
      refresh = 1'b0; req_valid = 1'b0; single_bank = new_mode;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         refresh = 1'b0; req_valid = 1'b0;
      end
   endtask

   // monitor: pops one expected decision for each rsp_valid
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "rsp_valid without request", 1, 0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(rsp_act == e.act, t, "rsp_act", rsp_act, e.act);
               check(rsp_slot == e.slot, t, "rsp_slot", rsp_slot, e.slot);
               check(rsp_close_bank == e.close, t, "rsp_close_bank", rsp_close_bank, e.close);
               check(rsp_bank == e.bank && rsp_row == e.row, t, "rsp_bank/row",
                     {rsp_bank, rsp_row}, {e.bank, e.row});
            end
         end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            check(1'b0, "R8", "rsp_valid one cycle after accept", 0, 1);
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
         end
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      for (int s = 0; s < SLOTS; s++) begin
         m_valid[s] = 1'b0; m_bank[s] = '0; m_row[s] = '0; m_order.push_back(s);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
      check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

      // fill the four slots, with a hit and a swap in between
      issue(3'd1, 14'd10, "R3");
      issue(3'd2, 14'd20, "R3");
      issue(3'd1, 14'd10, "R2");
      issue(3'd3, 14'd30, "R3");
      issue(3'd4, 14'd40, "R3");
      issue(3'd2, 14'd21, "R4");
      idle(2);
      // bank 1 was opened first; a hit makes it newest, so bank 3 is evicted
      issue(3'd1, 14'd10, "R6");
      issue(3'd5, 14'd50, "R6");
      issue(3'd6, 14'd60, "R10");
      issue(3'd7, 14'd70, "R10");
      idle(1);

      // refresh while a request is offered: the request is not taken
      do_refresh(1'b1, 1'b0);
      issue(3'd1, 14'd10, "R9");
      issue(3'd2, 14'd20, "R9");

      // single open bank mode
      do_refresh(1'b0, 1'b1);
      issue(3'd2, 14'd5, "R7");
      issue(3'd2, 14'd5, "R7");
      issue(3'd3, 14'd7, "R7");
      issue(3'd3, 14'd8, "R7");
      issue(3'd0, 14'd1, "R7");
      idle(1);

      // pseudo-random mixes in both modes
      for (int pass = 0; pass < 2; pass++) begin
         do_refresh(1'b0, pass == 1);
         for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:5] == 3'd0) idle(1);
            issue(lfsr[2:0], ROW_W'(lfsr[4:3]), "");
         end
         idle(2);
      end

      idle(3);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule